// File: doc/BRIEF.md
# Byte-Loadable Cursor Address Counter

This block holds the 16-bit pointer that selects the display memory location used by host data transfers. Software presets the pointer one byte at a time: one command writes the high-order byte and another writes the low-order byte. After that, the pointer advances by one each time a memory read or write finishes. It also advances by one after each single-bit set or clear operation. The RAM transfer logic reports each finished operation with a one-cycle strobe.

The counter behaves like a ripple up-counter, including during byte loads. If a low-byte load makes bit 7 of the low byte fall from 1 to 0, the high byte gains one. Software must therefore write the low byte first and the high byte second to get an exact address. The full pointer is always available to the cursor comparator. A second output feeds the RAM address multiplexer. In character mode the top four lines of that output carry the character line code instead of pointer bits.

Top module: `cursor_addr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr` becomes 0x0000 at that edge.
- R2: A cycle with `access_done` high and no load command raises `addr` by exactly one.
- R3: A cycle with `bitop_done` high and no load command raises `addr` by exactly one. When `bitop_done` and `access_done` are both high, `addr` still rises by only one.
- R4: Incrementing from 0xFFFF gives 0x0000.
- R5: `load_hi` alone writes `load_data` into `addr[15:8]`. It leaves `addr[7:0]` unchanged and never produces a carry.
- R6: `load_lo` writes `load_data` into `addr[7:0]`. If the old `addr[7]` was 1 and `load_data[7]` is 0, `addr[15:8]` rises by one, wrapping 0xFF to 0x00. Otherwise `addr[15:8]` is unchanged.
- R7: When a load command and an increment strobe are high in the same cycle, only the load takes effect and the increment is dropped.
- R8: When `load_lo` and `load_hi` are high together, only the low-byte load (with its R6 carry) is applied and `load_hi` is ignored.
- R9: A cycle with no load, no strobe and no reset leaves `addr` unchanged.
- R10: `ram_addr` equals `addr` when `char_mode` is 0. When `char_mode` is 1, `ram_addr` is `{line_code, addr[11:0]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_lo | input | 1 | Load `load_data` into the low byte |
| load_hi | input | 1 | Load `load_data` into the high byte |
| load_data | input | 8 | Byte value for either load command |
| access_done | input | 1 | One-cycle strobe: a RAM data read or write finished |
| bitop_done | input | 1 | One-cycle strobe: a bit set or clear finished |
| char_mode | input | 1 | 1 selects character mode addressing |
| line_code | input | 4 | Character line code placed on the top RAM address lines in character mode |
| addr | output | 16 | Current pointer value, sent to the cursor comparator |
| ram_addr | output | 16 | Address sent to the RAM address multiplexer |

## Verification
The bench drives random mixes of strobes, loads and idle cycles and compares every cycle against a reference model. This shows whether increments, holds and the two load kinds are told apart.

Directed sequences cover specific corner cases:
- a low-byte load over an old bit 7 of 1, with new bit 7 both 0 and 1, to separate the carrying case from the plain case;
- that carry landing on a high byte of 0xFF;
- the wrap from 0xFFFF;
- both strobes together, so a double count cannot pass;
- a load colliding with a strobe, and both loads together, which expose the wrong priority.

Random `char_mode` and `line_code` values show whether the address output substitutes exactly the top four bits.

// File: rtl/cursor_addr_counter.sv
module cursor_addr_counter #(
  parameter int BYTE_W = 8,
  parameter int LINE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic [BYTE_W-1:0]   load_data,
  input  logic                access_done,
  input  logic                bitop_done,
  input  logic                char_mode,
  input  logic [LINE_W-1:0]   line_code,
  output logic [2*BYTE_W-1:0] addr,
  output logic [2*BYTE_W-1:0] ram_addr
);
  localparam int AW    = 2 * BYTE_W;
  localparam int KEEPW = AW - LINE_W;

  logic [BYTE_W-1:0] lo_q, hi_q;

  wire step     = access_done | bitop_done;
  wire lo_carry = lo_q[BYTE_W-1] & ~load_data[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_lo) begin
      lo_q <= load_data;
      hi_q <= hi_q + BYTE_W'(lo_carry);
    end else if (load_hi) begin
      hi_q <= load_data;
    end else if (step) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + AW'(1);
    end
  end

  assign addr     = {hi_q, lo_q};
  assign ram_addr = char_mode ? {line_code, addr[KEEPW-1:0]} : addr;
endmodule

// File: rtl/cursor_addr_counter_chk.sv
module cursor_addr_counter_chk #(
  parameter int BYTE_W = 8,
  parameter int LINE_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                load_lo,
  input logic                load_hi,
  input logic [BYTE_W-1:0]   load_data,
  input logic                access_done,
  input logic                bitop_done,
  input logic                char_mode,
  input logic [LINE_W-1:0]   line_code,
  input logic [2*BYTE_W-1:0] addr,
  input logic [2*BYTE_W-1:0] ram_addr
);
  localparam int AW = 2 * BYTE_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> addr == '0);

  // R2
  step_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_lo && !load_hi && (access_done || bitop_done)) |=> addr == $past(addr) + AW'(1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_lo && !load_hi && !access_done && !bitop_done) |=> $stable(addr));

  // R5
  high_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_hi && !load_lo) |=>
      (addr[AW-1:BYTE_W] == $past(load_data)) && (addr[BYTE_W-1:0] == $past(addr[BYTE_W-1:0])));

  // R6
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_lo |=>
      (addr[BYTE_W-1:0] == $past(load_data)) &&
      (addr[AW-1:BYTE_W] == $past(addr[AW-1:BYTE_W]) +
         BYTE_W'($past(addr[BYTE_W-1]) & ~$past(load_data[BYTE_W-1]))));

  // R10
  char_addr_chk: assert property (@(posedge clk) disable iff (rst)
    char_mode |-> (ram_addr[AW-1:AW-LINE_W] == line_code) &&
                  (ram_addr[AW-LINE_W-1:0] == addr[AW-LINE_W-1:0]));

  // R10
  graphic_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !char_mode |-> ram_addr == addr);
endmodule

bind cursor_addr_counter cursor_addr_counter_chk #(.BYTE_W(BYTE_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/cursor_addr_counter_tb.sv
module cursor_addr_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_lo = 1'b0, load_hi = 1'b0;
  logic [7:0]  load_data = 8'h00;
  logic        access_done = 1'b0, bitop_done = 1'b0;
  logic        char_mode = 1'b0;
  logic [3:0]  line_code = 4'h0;
  logic [15:0] addr, ram_addr;

  int checks = 0, errors = 0;
  logic [15:0] exp_addr = 16'h0000;

  always #10 clk = ~clk;

  cursor_addr_counter u_dut (
    .clk(clk), .rst(rst), .load_lo(load_lo), .load_hi(load_hi),
    .load_data(load_data), .access_done(access_done), .bitop_done(bitop_done),
    .char_mode(char_mode), .line_code(line_code), .addr(addr), .ram_addr(ram_addr)
  );

  function automatic logic [15:0] model(logic [15:0] a, logic r, logic ll, logic lh,
                                        logic [7:0] d, logic ad, logic bd);
    logic [7:0] hi;
    if (r) return 16'h0000;
    if (ll) begin
      hi = a[15:8];
      if (a[7] && !d[7]) hi = hi + 8'd1;
      return {hi, d};
    end
    if (lh) return {d, a[7:0]};
    if (ad || bd) return a + 16'd1;
    return a;
  endfunction

  function automatic string tag_of(logic r, logic ll, logic lh, logic ad, logic bd, logic [15:0] a);
    if (r) return "R1";
    if (ll && lh) return "R8";
    if ((ll || lh) && (ad || bd)) return "R7";
    if (ll) return "R6";
    if (lh) return "R5";
    if ((ad || bd) && a == 16'hFFFF) return "R4";
    if (bd) return "R3";
    if (ad) return "R2";
    return "R9";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_ram;
    logic [15:0] e;
    e = char_mode ? {line_code, addr[11:0]} : addr;
    check("R10", ram_addr, e);
  endtask

  task automatic step(logic r, logic ll, logic lh, logic [7:0] d, logic ad, logic bd);
    string t;
    t = tag_of(r, ll, lh, ad, bd, exp_addr);
    rst = r; load_lo = ll; load_hi = lh; load_data = d;
    access_done = ad; bitop_done = bd;
    exp_addr = model(exp_addr, r, ll, lh, d, ad, bd);
    @(negedge clk);
    check(t, addr, exp_addr);
    check_ram();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_junk;
    seed_junk = $urandom(32'd1234);
    @(negedge clk);
    step(1, 0, 0, 8'h00, 0, 0);
    check("R1", addr, 16'h0000);
    // R5 then R6 with and without carry
    step(0, 0, 1, 8'h12, 0, 0);
    step(0, 1, 0, 8'h80, 0, 0);
    step(0, 1, 0, 8'h05, 0, 0);
    check("R6", addr, 16'h1305);
    step(0, 1, 0, 8'hC0, 0, 0);
    step(0, 1, 0, 8'hFF, 0, 0);
    check("R6", addr, 16'h13FF);
    // R6 carry wraps a high byte of 0xFF
    step(0, 0, 1, 8'hFF, 0, 0);
    step(0, 1, 0, 8'h01, 0, 0);
    check("R6", addr, 16'h0001);
    // R4 wrap
    step(0, 0, 1, 8'hFF, 0, 0);
    step(0, 1, 0, 8'hFF, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0);
    check("R4", addr, 16'h0000);
    // R3 both strobes
    step(0, 0, 0, 8'h00, 1, 1);
    check("R3", addr, 16'h0001);
    step(0, 0, 0, 8'h00, 0, 1);
    // R7 load vs strobe
    step(0, 0, 1, 8'h40, 1, 1);
    check("R7", addr, 16'h4002);
    // R8 both loads
    step(0, 1, 1, 8'h7F, 0, 0);
    check("R8", addr, 16'h407F);
    // R9 idle
    step(0, 0, 0, 8'hAA, 0, 0);
    char_mode = 1; line_code = 4'hB;
    step(0, 0, 0, 8'h00, 1, 0);
    char_mode = 0;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      char_mode = rv[20];
      line_code = rv[24:21];
      step(rv[31:28] == 4'h0, rv[0] & rv[1], rv[2] & rv[3], rv[15:8],
           rv[4], rv[5] & rv[6]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule